// File: doc/BRIEF.md
# Refresh and Mode-Register Timer

This block keeps the maintenance-side timing of a DRAM command stream. It watches every command the controller puts on the bus, together with a level that says all banks are precharged. From these it raises a refresh request once per refresh interval and reports, for each class of command, whether that class may go out in the present cycle. REFRESH, MRS and the remaining bank or column commands (ACTIVATE, PRECHARGE, READ, WRITE) form the three classes.

A REFRESH is eligible only after the banks have sat idle for the precharge time, with no ACTIVATE or PRECHARGE in between. After a REFRESH, a recovery window shuts out every command except deselect. After an MRS, a short gap holds off the next MRS and a longer gap holds off every other non-deselect command. A command presented while its class is blocked is treated as not issued: it moves no timer, and the violation output pulses high for one cycle.

The scheduler sits beside the command arbiter. The arbiter reads the three permission outputs before it picks a command, and it treats the refresh request as a pending job of high priority.

Top module: `dram_maint_timer`

## Requirements
- R1: While reset is held, refreshReq and violation are 0, allowMrs and allowOther are 1, and allowRef is 0.
- R2: refreshReq rises exactly REFI_CYC cycles after reset release or after the last accepted REFRESH. It stays high until a REFRESH is accepted and is low in the cycle after that acceptance.
- R3: allowRef needs allBanksIdle to have been high for RP_CYC consecutive cycles with no accepted ACTIVATE or PRECHARGE. A low allBanksIdle, an accepted ACTIVATE or an accepted PRECHARGE restarts that count from zero.
- R4: After a REFRESH accepted at edge n, every non-deselect command is blocked at edges n+1 through n+RFC_CYC-1. The first edge at which commands are allowed again is n+RFC_CYC.
- R5: After an MRS accepted at edge n, another MRS is blocked through edge n+MRD_CYC-1 and is allowed at edge n+MRD_CYC.
- R6: After an MRS accepted at edge n, REFRESH, ACTIVATE, PRECHARGE, READ and WRITE are blocked through edge n+MOD_CYC-1.
- R7: A deselect (cmdType 0 with cmdValid high) or a cycle with cmdValid low never raises violation and changes no timer, whatever cmdType holds.
- R8: A command presented while its class is not allowed sets violation high for exactly the one cycle after its edge. The command is discarded and starts no window and no interval.
- R9: The cmdType encoding is 0 deselect, 1 ACTIVATE, 2 PRECHARGE, 3 REFRESH, 4 MRS, 5 READ, 6 WRITE. Code 7 is handled as a READ/WRITE-class command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is on the bus this cycle |
| cmdType | input | 3 | Command code (see R9) |
| allBanksIdle | input | 1 | All banks are precharged and idle |
| refreshReq | output | 1 | A refresh is due |
| allowRef | output | 1 | A REFRESH may issue this cycle |
| allowMrs | output | 1 | An MRS may issue this cycle |
| allowOther | output | 1 | ACTIVATE, PRECHARGE, READ or WRITE may issue this cycle |
| violation | output | 1 | The previous cycle's command broke a timing window |

## Verification
The refresh interval can expire while a post-MRS gap is still open. In that cycle the request and the blocking meet. The bench issues an MRS two cycles before the interval runs out and then presents a REFRESH while the gap is still closed. That REFRESH must be flagged as a violation and must leave refreshReq high. A REFRESH presented in the first cycle after the gap closes must then clear the request.

// File: rtl/maint_pkg.sv
package maint_pkg;

  typedef enum logic [2:0] {
    CMD_DES   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_PRE   = 3'd2,
    CMD_REF   = 3'd3,
    CMD_MRS   = 3'd4,
    CMD_RD    = 3'd5,
    CMD_WR    = 3'd6,
    CMD_SPARE = 3'd7
  } cmdCode_e;

  // Strobes from control to datapath: commands actually accepted.
  typedef struct packed {
    logic refGo;
    logic mrsGo;
    logic bankTouch;
  } ctrlStrobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic refiDue;
    logic rpMet;
    logic rfcBusy;
    logic mrdBusy;
    logic modBusy;
  } dpStatus_t;

endpackage

// File: rtl/maint_window_timer.sv
// Blocking window: after a load at edge n, busy stays high until edge n+LEN-1.
module maint_window_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  generate
    if (LEN > 1) begin : g_cnt
      logic [CW-1:0] remain;
      always_ff @(posedge clk) begin
        if (!rstN)               remain <= '0;
        else if (load)           remain <= CW'(LEN - 1);
        else if (remain != '0)   remain <= remain - 1'b1;
      end
      assign busy = (remain != '0);
    end else begin : g_none
      logic unusedIn;
      assign unusedIn = ^{clk, rstN, load};
      assign busy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/maint_datapath.sv
module maint_datapath
  import maint_pkg::*;
#(
  parameter int unsigned REFI_CYC = 200,
  parameter int unsigned RP_CYC   = 4,
  parameter int unsigned RFC_CYC  = 10,
  parameter int unsigned MRD_CYC  = 4,
  parameter int unsigned MOD_CYC  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        allBanksIdle,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);
  localparam int unsigned RW = $clog2(REFI_CYC + 1);
  localparam int unsigned IW = (RP_CYC > 0) ? $clog2(RP_CYC + 1) : 1;
  localparam int unsigned NWIN = 3;
  localparam int unsigned WIN_LEN [NWIN] = '{RFC_CYC, MRD_CYC, MOD_CYC};

  logic [RW-1:0] refiCnt;
  logic [IW-1:0] idleCnt;
  logic [NWIN-1:0] winLoad;
  logic [NWIN-1:0] winBusy;

  // Interval counter: saturates at the limit, reloads on an accepted refresh.
  always_ff @(posedge clk) begin
    if (!rstN)                          refiCnt <= '0;
    else if (strobe.refGo)              refiCnt <= '0;
    else if (refiCnt != RW'(REFI_CYC))  refiCnt <= refiCnt + 1'b1;
  end

  // Idle counter: restarts on bank activity or when banks are not idle.
  always_ff @(posedge clk) begin
    if (!rstN)                                idleCnt <= '0;
    else if (!allBanksIdle || strobe.bankTouch) idleCnt <= '0;
    else if (idleCnt != IW'(RP_CYC))          idleCnt <= idleCnt + 1'b1;
  end

  assign winLoad = {strobe.mrsGo, strobe.mrsGo, strobe.refGo};

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      maint_window_timer #(.LEN(WIN_LEN[w])) i_win (
        .clk  (clk),
        .rstN (rstN),
        .load (winLoad[w]),
        .busy (winBusy[w])
      );
    end
  endgenerate

  assign status.refiDue = (refiCnt == RW'(REFI_CYC));
  assign status.rpMet   = (idleCnt == IW'(RP_CYC));
  assign status.rfcBusy = winBusy[0];
  assign status.mrdBusy = winBusy[1];
  assign status.modBusy = winBusy[2];
endmodule

// File: rtl/maint_ctrl.sv
module maint_ctrl
  import maint_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdType,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        allowRef,
  output logic        allowMrs,
  output logic        allowOther,
  output logic        violation
);
  logic legal;
  logic go;

  assign allowOther = !status.rfcBusy && !status.modBusy;
  assign allowMrs   = !status.rfcBusy && !status.mrdBusy;
  assign allowRef   = allowOther && status.rpMet;

  always_comb begin
    case (cmdCode_e'(cmdType))
      CMD_DES: legal = 1'b1;
      CMD_REF: legal = allowRef;
      CMD_MRS: legal = allowMrs;
      default: legal = allowOther;
    endcase
  end

  assign go               = cmdValid && legal;
  assign strobe.refGo     = go && (cmdType == CMD_REF);
  assign strobe.mrsGo     = go && (cmdType == CMD_MRS);
  assign strobe.bankTouch = go && ((cmdType == CMD_ACT) || (cmdType == CMD_PRE));

  always_ff @(posedge clk) begin
    if (!rstN) violation <= 1'b0;
    else       violation <= cmdValid && !legal;
  end
endmodule

// File: rtl/dram_maint_timer.sv
module dram_maint_timer
  import maint_pkg::*;
#(
  parameter int unsigned REFI_CYC = 200,
  parameter int unsigned RP_CYC   = 4,
  parameter int unsigned RFC_CYC  = 10,
  parameter int unsigned MRD_CYC  = 4,
  parameter int unsigned MOD_CYC  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdType,
  input  logic       allBanksIdle,
  output logic       refreshReq,
  output logic       allowRef,
  output logic       allowMrs,
  output logic       allowOther,
  output logic       violation
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  maint_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdType    (cmdType),
    .status     (status),
    .strobe     (strobe),
    .allowRef   (allowRef),
    .allowMrs   (allowMrs),
    .allowOther (allowOther),
    .violation  (violation)
  );

  maint_datapath #(
    .REFI_CYC (REFI_CYC),
    .RP_CYC   (RP_CYC),
    .RFC_CYC  (RFC_CYC),
    .MRD_CYC  (MRD_CYC),
    .MOD_CYC  (MOD_CYC)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .allBanksIdle (allBanksIdle),
    .strobe       (strobe),
    .status       (status)
  );

  assign refreshReq = status.refiDue;
endmodule

// File: rtl/maint_timer_chk.sv
module maint_timer_chk
  import maint_pkg::*;
#(
  parameter int unsigned RP_CYC  = 4,
  parameter int unsigned RFC_CYC = 10,
  parameter int unsigned MRD_CYC = 4,
  parameter int unsigned MOD_CYC = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdType,
  input logic       allBanksIdle,
  input logic       refreshReq,
  input logic       allowRef,
  input logic       allowMrs,
  input logic       allowOther,
  input logic       violation
);
  logic refTake;
  logic mrsTake;
  assign refTake = cmdValid && (cmdType == CMD_REF) && allowRef;
  assign mrsTake = cmdValid && (cmdType == CMD_MRS) && allowMrs;

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    refTake |=> !refreshReq);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refTake) |=> refreshReq);

  // R3
  rp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (RP_CYC > 0 && !allBanksIdle) |=> !allowRef);

  // R4
  rfc_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (RFC_CYC > 1 && refTake) |=> (!allowOther && !allowMrs && !allowRef));

  // R5
  mrd_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (MRD_CYC > 1 && mrsTake) |=> !allowMrs);

  // R6
  mod_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (MOD_CYC > 1 && mrsTake) |=> (!allowOther && !allowRef));

  // R7
  des_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdType == CMD_DES) |=> !violation);

  // R8
  vio_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == CMD_ACT && !allowOther) |=> violation);
endmodule

bind dram_maint_timer maint_timer_chk #(
  .RP_CYC  (RP_CYC),
  .RFC_CYC (RFC_CYC),
  .MRD_CYC (MRD_CYC),
  .MOD_CYC (MOD_CYC)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdValid     (cmdValid),
  .cmdType      (cmdType),
  .allBanksIdle (allBanksIdle),
  .refreshReq   (refreshReq),
  .allowRef     (allowRef),
  .allowMrs     (allowMrs),
  .allowOther   (allowOther),
  .violation    (violation)
);

// File: tb/test_dram_maint_timer.sv
module test_dram_maint_timer;
  import maint_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int REFI = 200;
  localparam int RP   = 4;
  localparam int RFC  = 10;
  localparam int MRD  = 4;
  localparam int MOD  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdType = 3'd0;
  logic allBanksIdle = 1'b1;
  logic refreshReq, allowRef, allowMrs, allowOther, violation;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_maint_timer #(
    .REFI_CYC (REFI), .RP_CYC (RP), .RFC_CYC (RFC), .MRD_CYC (MRD), .MOD_CYC (MOD)
  ) i_dram_maint_timer (
    .clk (clk), .rstN (rstN), .cmdValid (cmdValid), .cmdType (cmdType),
    .allBanksIdle (allBanksIdle), .refreshReq (refreshReq), .allowRef (allowRef),
    .allowMrs (allowMrs), .allowOther (allowOther), .violation (violation)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] t);
    cmdValid = 1'b1;
    cmdType  = t;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdType  = CMD_DES;
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 refreshReq in reset", int'(refreshReq), 0);
    chk("R1 violation in reset", int'(violation), 0);
    chk("R1 allowRef in reset", int'(allowRef), 0);
    chk("R1 allowMrs in reset", int'(allowMrs), 1);
    chk("R1 allowOther in reset", int'(allowOther), 1);
    rstN = 1'b1;
  endtask

  task automatic t_interval;
    tick(REFI - 1);
    chk("R2 req low one cycle early", int'(refreshReq), 0);
    tick(1);
    chk("R2 req rises after interval", int'(refreshReq), 1);
    tick(5);
    chk("R2 req held while pending", int'(refreshReq), 1);
  endtask

  task automatic t_refresh;
    chk("R3 allowRef after long idle", int'(allowRef), 1);
    issue(CMD_REF);                       // edge 0
    chk("R2 req drops after refresh", int'(refreshReq), 0);
    chk("R4 other blocked", int'(allowOther), 0);
    chk("R4 mrs blocked", int'(allowMrs), 0);
    chk("R4 ref blocked", int'(allowRef), 0);
    issue(CMD_ACT);                       // edge 1
    chk("R8 act in rfc flagged", int'(violation), 1);
    issue(CMD_DES);                       // edge 2
    chk("R7 deselect in rfc clean", int'(violation), 0);
    tick(RFC - 5);                        // after edge RFC-3
    chk("R4 other still blocked", int'(allowOther), 0);
    issue(CMD_MRS);                       // edge RFC-2
    chk("R8 mrs in rfc flagged", int'(violation), 1);
    chk("R4 blocked at last window cycle", int'(allowOther), 0);
    tick(1);                              // after edge RFC-1
    chk("R4 other free at window end", int'(allowOther), 1);
    chk("R8 rejected mrs started no window", int'(allowMrs), 1);
    chk("R8 flag lasts one cycle", int'(violation), 0);
    tick(REFI - RFC);                     // after edge REFI-1
    chk("R2 req low before next interval", int'(refreshReq), 0);
    tick(1);
    chk("R2 req rises after refresh interval", int'(refreshReq), 1);
  endtask

  task automatic t_precharge;
    issue(CMD_PRE);                       // edge 0
    chk("R3 precharge restarts idle", int'(allowRef), 0);
    issue(CMD_REF);                       // edge 1
    chk("R8 early refresh flagged", int'(violation), 1);
    chk("R8 rejected refresh keeps req", int'(refreshReq), 1);
    tick(RP - 2);                         // after edge RP-1
    chk("R3 idle one short", int'(allowRef), 0);
    tick(1);
    chk("R3 idle met", int'(allowRef), 1);
    allBanksIdle = 1'b0;
    tick(1);
    allBanksIdle = 1'b1;
    chk("R3 busy bank clears", int'(allowRef), 0);
    tick(RP - 1);
    chk("R3 after busy one short", int'(allowRef), 0);
    tick(1);
    chk("R3 after busy met", int'(allowRef), 1);
    issue(CMD_ACT);
    chk("R3 activate restarts idle", int'(allowRef), 0);
    tick(RP);
    chk("R3 idle met after activate", int'(allowRef), 1);
  endtask

  task automatic t_mrs;
    issue(CMD_MRS);                       // edge 0
    chk("R5 mrs blocked", int'(allowMrs), 0);
    tick(MRD - 2);                        // after edge MRD-2
    chk("R5 mrs blocked at gap end", int'(allowMrs), 0);
    tick(1);
    chk("R5 mrs free", int'(allowMrs), 1);
    chk("R6 other still blocked", int'(allowOther), 0);
    chk("R6 ref still blocked", int'(allowRef), 0);
    tick(MOD - MRD - 1);                  // after edge MOD-2
    chk("R6 other blocked at gap end", int'(allowOther), 0);
    tick(1);
    chk("R6 other free", int'(allowOther), 1);
    chk("R6 ref free", int'(allowRef), 1);
    issue(CMD_MRS);                       // edge 0
    tick(MRD - 1);
    issue(CMD_MRS);                       // edge MRD
    chk("R5 mrs at exact gap legal", int'(violation), 0);
    chk("R6 second mrs reopens gap", int'(allowOther), 0);
    issue(CMD_MRS);                       // one cycle later
    chk("R5 mrs too soon flagged", int'(violation), 1);
    issue(CMD_RD);
    chk("R6 read too soon flagged", int'(violation), 1);
    tick(MOD + 1);
    chk("R6 window cleared", int'(allowOther), 1);
  endtask

  task automatic t_overlap;
    chk("R3 ref allowed before overlap", int'(allowRef), 1);
    issue(CMD_REF);                       // edge 0
    tick(REFI - 3);
    issue(CMD_MRS);                       // edge REFI-2
    chk("R2 req low before overlap", int'(refreshReq), 0);
    tick(2);                              // after edge REFI
    chk("R2 req rises under mod gap", int'(refreshReq), 1);
    chk("R6 ref blocked under mod gap", int'(allowRef), 0);
    issue(CMD_REF);                       // edge REFI+1
    chk("R8 refresh in mod gap flagged", int'(violation), 1);
    chk("R8 rejected refresh keeps req", int'(refreshReq), 1);
    cmdType = CMD_REF;                    // not valid: must be ignored
    tick(1);
    cmdType = CMD_DES;
    chk("R7 invalid cycle clean", int'(violation), 0);
    chk("R7 invalid cycle keeps req", int'(refreshReq), 1);
    chk("R6 ref blocked last gap cycle", int'(allowRef), 0);
    tick(MOD - 5);
    chk("R6 ref free after gap", int'(allowRef), 1);
    issue(CMD_REF);
    chk("R2 req clears after late refresh", int'(refreshReq), 0);
    chk("R9 refresh code accepted", int'(violation), 0);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_refresh();
    t_precharge();
    t_mrs();
    t_overlap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule